// File: doc/BRIEF.md
# Oversampling Serial Character Receiver

This block recovers asynchronous serial characters from a single input line. An enable pulse runs at sixteen times the bit rate and paces the receiver. The divider that makes this pulse sits outside the block and is shared with the transmitter. The line passes through a synchroniser and a glitch filter. A falling edge starts a character, and the receiver checks that edge again at the middle of the start bit. Because timing restarts at every start bit, rate mismatch can only build up over one character.

Each finished character goes into a holding register. A ready flag follows one clock later. The same word-length and parity settings as the transmitter select the frame, but the receiver always checks exactly one stop bit. Four sticky error flags report overrun, parity, framing and break. Reading the data clears the ready flag, and reading the status clears the four error flags. Two test inputs force a parity or framing error onto every received character.

Top module: `serial_rx_core`

## Requirements
- R1: After a synchronous active-low reset, `rx_data` is zero and `data_ready`, `err_overrun`, `err_parity`, `err_framing` and `err_break` are all low.
- R2: Data bits arrive least significant first. `word_len` selects 5, 6, 7 or 8 bits for the codes 0, 1, 2 and 3. Unused upper bits of `rx_data` read as zero. Each bit is sampled at the midpoint of its sixteen sample pulses.
- R3: When `par_en` is high, one parity bit follows the data. With `par_odd` low, the data bits plus the parity bit must hold an even number of ones; with `par_odd` high, an odd number. A mismatch sets `err_parity`. When `par_en` is low, no parity bit is expected.
- R4: A low pulse on `rx_in` that lasts fewer than two sample pulses is ignored and starts no character.
- R5: If the line is high again at the midpoint of the start bit, the start is discarded and no character is delivered.
- R6: A finished character updates `rx_data` and the error flags. `data_ready` rises on the next clock. A `rd_data_strobe` clears `data_ready`.
- R7: If a character finishes while `data_ready` (or its pending load) is still set, `err_overrun` is set, `rx_data` keeps the older character, and the new character's other errors are dropped.
- R8: Only one stop bit is checked. A low stop bit sets `err_framing`. After a low stop bit, the receiver waits for the line to return high before it will accept another start.
- R9: If every data bit, the parity bit (when enabled) and the stop bit are all sampled low, both `err_break` and `err_framing` are set.
- R10: A `rd_status_strobe` clears all four error flags. When a flag is set in the same clock as its clear strobe, setting wins. The same holds for `data_ready` against `rd_data_strobe`.
- R11: `force_perr` sets `err_parity`, and `force_ferr` sets `err_framing`, on every received character. This applies even when parity is disabled or the stop bit is good.
- R12: The receiver's state advances only in clocks where `samp_tick` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| samp_tick | input | 1 | Sample enable at sixteen times the bit rate |
| rx_in | input | 1 | Asynchronous serial line, idle high |
| word_len | input | 2 | Data bits minus five |
| par_en | input | 1 | Parity bit present |
| par_odd | input | 1 | Odd parity when high, even when low |
| force_perr | input | 1 | Test: force a parity error on each character |
| force_ferr | input | 1 | Test: force a framing error on each character |
| rd_data_strobe | input | 1 | Buffer read, clears `data_ready` |
| rd_status_strobe | input | 1 | Status read, clears the error flags |
| rx_data | output | 8 | Last accepted character |
| data_ready | output | 1 | A character is waiting |
| err_overrun | output | 1 | A character was lost |
| err_parity | output | 1 | Parity mismatch |
| err_framing | output | 1 | Stop bit sampled low |
| err_break | output | 1 | Whole frame sampled low |

## Verification
Setting a flag and clearing it by read can fall in the same clock. This applies to an error flag against the status read and to `data_ready` against the buffer read. The bench provokes the collision by holding both read strobes high for a whole character that carries a parity error. Both `err_parity` and `data_ready` must then be seen high for at least one clock, which shows that the set beats the clear. Overrun and a still-pending ready flag are also exercised together, by sending two characters with no read between them.

// File: rtl/srx_pkg.sv
// Shared types for the serial receiver.
// Assumes: characters are at most 8 bits wide in the result record.
package srx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP,
        ST_WAITHI
    } rx_state_t;

    typedef struct packed {
        logic [7:0] data;
        logic       perr;
        logic       ferr;
        logic       brk;
    } rx_result_t;

endpackage

// File: rtl/srx_filter.sv
// Synchronises the raw line and removes short pulses.
// The filtered level follows the synchronised line only after the new level
// has been seen on FILT_TICKS consecutive sample pulses.
// Assumes: the line idles high; tick is a single-clock enable.
module srx_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_TICKS  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic rx_in,
    output logic line_q
);
    localparam int CW = $clog2(FILT_TICKS + 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic [CW-1:0]          run_cnt;
    logic                   sampled;

    assign sampled = sync_q[SYNC_STAGES-1];

    // Purpose: move the asynchronous line into the clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], rx_in};
    end

    // Purpose: accept a new level only after it persists for FILT_TICKS pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_q  <= 1'b1;
            run_cnt <= '0;
        end else if (tick) begin
            if (sampled != line_q) begin
                if (run_cnt == CW'(FILT_TICKS - 1)) begin
                    line_q  <= sampled;
                    run_cnt <= '0;
                end else begin
                    run_cnt <= run_cnt + 1'b1;
                end
            end else begin
                run_cnt <= '0;
            end
        end
    end
endmodule

// File: rtl/srx_engine.sv
// Frame sequencer: detects a start, confirms it at the middle of the bit,
// samples data, parity and one stop bit at bit midpoints, and emits a
// one-clock done pulse with the character and its error bits.
// Assumes: tick runs at OVS times the bit rate; DATA_W is 8 (word_len adds 0..3
// bits to DATA_W-3).
module srx_engine
    import srx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OVS    = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick,
    input  logic        line,
    input  logic [1:0]  word_len,
    input  logic        par_en,
    input  logic        par_odd,
    input  logic        force_perr,
    input  logic        force_ferr,
    output logic        done,
    output rx_result_t  result
);
    localparam int CNT_W    = $clog2(OVS);
    localparam int IDX_W    = $clog2(DATA_W);
    localparam int MIN_BITS = DATA_W - 3;
    localparam logic [CNT_W-1:0] MID  = CNT_W'(OVS / 2 - 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(OVS - 1);

    rx_state_t          state;
    logic [CNT_W-1:0]   cnt;
    logic [IDX_W-1:0]   bit_idx;
    logic [IDX_W-1:0]   last_idx;
    logic [DATA_W-1:0]  shreg;
    logic               par_acc;
    logic               all_low;

    assign last_idx = IDX_W'(MIN_BITS - 1) + IDX_W'(word_len);

    // Purpose: step through the frame on sample pulses and publish the result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            cnt     <= '0;
            bit_idx <= '0;
            shreg   <= '0;
            par_acc <= 1'b0;
            all_low <= 1'b1;
            done    <= 1'b0;
            result  <= '0;
        end else begin
            done <= 1'b0;
            if (tick) begin
                case (state)
                    ST_IDLE: begin
                        if (!line) begin
                            state <= ST_START;
                            cnt   <= '0;
                        end
                    end
                    ST_START: begin
                        if (cnt == MID) begin
                            cnt <= '0;
                            if (line) begin
                                state <= ST_IDLE;
                            end else begin
                                state   <= ST_DATA;
                                bit_idx <= '0;
                                shreg   <= '0;
                                par_acc <= 1'b0;
                                all_low <= 1'b1;
                            end
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_DATA: begin
                        if (cnt == LAST) begin
                            cnt            <= '0;
                            shreg[bit_idx] <= line;
                            par_acc        <= par_acc ^ line;
                            all_low        <= all_low & ~line;
                            if (bit_idx == last_idx) begin
                                bit_idx <= '0;
                                state   <= par_en ? ST_PAR : ST_STOP;
                            end else begin
                                bit_idx <= bit_idx + 1'b1;
                            end
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_PAR: begin
                        if (cnt == LAST) begin
                            cnt     <= '0;
                            par_acc <= par_acc ^ line;
                            all_low <= all_low & ~line;
                            state   <= ST_STOP;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_STOP: begin
                        if (cnt == LAST) begin
                            cnt         <= '0;
                            done        <= 1'b1;
                            result.data <= shreg;
                            result.perr <= (par_en & (par_acc ^ par_odd)) | force_perr;
                            result.ferr <= ~line | force_ferr;
                            result.brk  <= ~line & all_low;
                            state       <= line ? ST_IDLE : ST_WAITHI;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_WAITHI: begin
                        if (line) state <= ST_IDLE;
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/srx_status.sv
// Holding register and sticky flags. Loads a character on done unless
// the previous one is unread, raises data_ready one clock after the load,
// and clears flags on read strobes; a set beats a clear in the same clock.
// Assumes: done is a single-clock pulse.
module srx_status
    import srx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              done,
    input  rx_result_t        result,
    input  logic              rd_data_strobe,
    input  logic              rd_status_strobe,
    output logic [DATA_W-1:0] rx_data,
    output logic              data_ready,
    output logic              load_pend,
    output logic              err_overrun,
    output logic              err_parity,
    output logic              err_framing,
    output logic              err_break
);
    logic occupied;
    logic take;
    logic lose;

    assign occupied = data_ready | load_pend;
    assign take     = done & ~occupied;
    assign lose     = done & occupied;

    // Purpose: capture accepted characters and delay the ready flag by one clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_data    <= '0;
            load_pend  <= 1'b0;
            data_ready <= 1'b0;
        end else begin
            load_pend <= done;
            if (take)           rx_data    <= result.data;
            if (load_pend)      data_ready <= 1'b1;
            else if (rd_data_strobe) data_ready <= 1'b0;
        end
    end

    // Purpose: sticky error flags, set by a character, cleared by a status read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_overrun <= 1'b0;
            err_parity  <= 1'b0;
            err_framing <= 1'b0;
            err_break   <= 1'b0;
        end else begin
            if (lose)                         err_overrun <= 1'b1;
            else if (rd_status_strobe)        err_overrun <= 1'b0;
            if (take & result.perr)           err_parity  <= 1'b1;
            else if (rd_status_strobe)        err_parity  <= 1'b0;
            if (take & result.ferr)           err_framing <= 1'b1;
            else if (rd_status_strobe)        err_framing <= 1'b0;
            if (take & result.brk)            err_break   <= 1'b1;
            else if (rd_status_strobe)        err_break   <= 1'b0;
        end
    end
endmodule

// File: rtl/serial_rx_core.sv
// Top of the serial receiver: filter, frame sequencer and status stage.
// Assumes: samp_tick is a one-clock pulse at sixteen times the bit rate,
// generated outside and shared with the transmitter.
module serial_rx_core
    import srx_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int OVS         = 16,
    parameter int SYNC_STAGES = 2,
    parameter int FILT_TICKS  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              samp_tick,
    input  logic              rx_in,
    input  logic [1:0]        word_len,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic              force_perr,
    input  logic              force_ferr,
    input  logic              rd_data_strobe,
    input  logic              rd_status_strobe,
    output logic [DATA_W-1:0] rx_data,
    output logic              data_ready,
    output logic              err_overrun,
    output logic              err_parity,
    output logic              err_framing,
    output logic              err_break
);
    logic       line_f;
    logic       rx_done;
    logic       load_pend;
    rx_result_t rx_res;

    srx_filter #(
        .SYNC_STAGES (SYNC_STAGES),
        .FILT_TICKS  (FILT_TICKS)
    ) u_filt (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (samp_tick),
        .rx_in  (rx_in),
        .line_q (line_f)
    );

    srx_engine #(
        .DATA_W (DATA_W),
        .OVS    (OVS)
    ) u_eng (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (samp_tick),
        .line       (line_f),
        .word_len   (word_len),
        .par_en     (par_en),
        .par_odd    (par_odd),
        .force_perr (force_perr),
        .force_ferr (force_ferr),
        .done       (rx_done),
        .result     (rx_res)
    );

    srx_status #(
        .DATA_W (DATA_W)
    ) u_stat (
        .clk              (clk),
        .rst_n            (rst_n),
        .done             (rx_done),
        .result           (rx_res),
        .rd_data_strobe   (rd_data_strobe),
        .rd_status_strobe (rd_status_strobe),
        .rx_data          (rx_data),
        .data_ready       (data_ready),
        .load_pend        (load_pend),
        .err_overrun      (err_overrun),
        .err_parity       (err_parity),
        .err_framing      (err_framing),
        .err_break        (err_break)
    );
endmodule

// File: rtl/srx_checker.sv
// Temporal checks on the receiver's outputs against its internal hand-off
// signals; attached to every instance of the top through bind.
module srx_checker #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rx_done,
    input logic              load_pend,
    input logic              rd_data_strobe,
    input logic              rd_status_strobe,
    input logic [DATA_W-1:0] rx_data,
    input logic              data_ready,
    input logic              err_overrun,
    input logic              err_parity,
    input logic              err_framing,
    input logic              err_break
);
    assert_buffer_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rx_data) |-> $past(rx_done));

    assert_ready_after_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(data_ready) |-> $past(load_pend));

    assert_read_clears_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data_strobe && !load_pend) |=> !data_ready);

    assert_overrun_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_overrun) |-> $past(data_ready || load_pend));

    assert_status_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_status_strobe && !rx_done) |=>
            (!err_overrun && !err_parity && !err_framing && !err_break));

    assert_break_framing_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_break) |-> err_framing);

    assert_single_done_R12: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done |=> !rx_done);
endmodule

bind serial_rx_core srx_checker #(.DATA_W(DATA_W)) u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .rx_done          (rx_done),
    .load_pend        (load_pend),
    .rd_data_strobe   (rd_data_strobe),
    .rd_status_strobe (rd_status_strobe),
    .rx_data          (rx_data),
    .data_ready       (data_ready),
    .err_overrun      (err_overrun),
    .err_parity       (err_parity),
    .err_framing      (err_framing),
    .err_break        (err_break)
);

// File: tb/serial_rx_core_test.sv
module serial_rx_core_test;
    localparam int TICKDIV = 2;
    localparam int BITCLK  = 16 * TICKDIV;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tdiv = 1'b0;
    logic       rx_in = 1'b1;
    logic [1:0] word_len = 2'd3;
    logic       par_en = 1'b0;
    logic       par_odd = 1'b0;
    logic       force_perr = 1'b0;
    logic       force_ferr = 1'b0;
    logic       rd_data_strobe = 1'b0;
    logic       rd_status_strobe = 1'b0;
    logic [7:0] rx_data;
    logic       data_ready, err_overrun, err_parity, err_framing, err_break;

    int checks = 0;
    int errors = 0;
    logic mon_en = 1'b0;
    logic seen_pe = 1'b0;
    logic seen_dr = 1'b0;

    always #2 clk = ~clk;
    always @(posedge clk) tdiv <= ~tdiv;

    serial_rx_core uut (
        .clk              (clk),
        .rst_n            (rst_n),
        .samp_tick        (tdiv),
        .rx_in            (rx_in),
        .word_len         (word_len),
        .par_en           (par_en),
        .par_odd          (par_odd),
        .force_perr       (force_perr),
        .force_ferr       (force_ferr),
        .rd_data_strobe   (rd_data_strobe),
        .rd_status_strobe (rd_status_strobe),
        .rx_data          (rx_data),
        .data_ready       (data_ready),
        .err_overrun      (err_overrun),
        .err_parity       (err_parity),
        .err_framing      (err_framing),
        .err_break        (err_break)
    );

    // Collision monitor: records flags seen while both reads are held.
    always @(negedge clk) begin
        if (mon_en && err_parity) seen_pe <= 1'b1;
        if (mon_en && data_ready) seen_dr <= 1'b1;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic hold(input logic v, input int n);
        rx_in = v;
        repeat (n) @(negedge clk);
    endtask

    task automatic send_frame(input logic [7:0] d, input logic flip_par, input logic stop_v);
        int n;
        logic [7:0] m;
        n = 5 + int'(word_len);
        m = 8'hFF >> (8 - n);
        hold(1'b0, BITCLK);
        for (int i = 0; i < n; i++) hold(d[i], BITCLK);
        if (par_en) hold((^(d & m)) ^ par_odd ^ flip_par, BITCLK);
        hold(stop_v, BITCLK);
        rx_in = 1'b1;
        repeat (8) @(negedge clk);
    endtask

    task automatic read_both();
        rd_data_strobe   = 1'b1;
        rd_status_strobe = 1'b1;
        @(negedge clk);
        rd_data_strobe   = 1'b0;
        rd_status_strobe = 1'b0;
        @(negedge clk);
    endtask

    function automatic logic [12:0] pack(input logic dr, input logic [7:0] d,
                                         input logic oe, input logic pe,
                                         input logic fe, input logic bi);
        return {dr, d, oe, pe, fe, bi};
    endfunction

    function automatic logic [12:0] observed();
        return pack(data_ready, rx_data, err_overrun, err_parity, err_framing, err_break);
    endfunction

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] m;
        logic [7:0] d;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check("R1 reset", 32'(observed()), 32'(pack(0, 8'h00, 0, 0, 0, 0)));

        // R2 / R12: all 256 values, 8 data bits, no parity
        word_len = 2'd3; par_en = 1'b0;
        for (int v = 0; v < 256; v++) begin
            send_frame(8'(v), 1'b0, 1'b1);
            check("R2 8N1 sweep", 32'(observed()), 32'(pack(1, 8'(v), 0, 0, 0, 0)));
            read_both();
        end

        // R2 / R3: every length and parity mode over a spread of values
        for (int wl = 0; wl < 4; wl++) begin
            for (int pm = 0; pm < 3; pm++) begin
                for (int k = 0; k < 8; k++) begin
                    word_len = 2'(wl);
                    par_en   = (pm != 0);
                    par_odd  = (pm == 2);
                    d = 8'((k * 37 + 5) ^ (wl * 11));
                    m = 8'hFF >> (3 - wl);
                    send_frame(d, 1'b0, 1'b1);
                    check("R2 R3 format sweep", 32'(observed()), 32'(pack(1, d & m, 0, 0, 0, 0)));
                    read_both();
                end
            end
        end

        // R3: wrong parity bit, even then odd
        word_len = 2'd3; par_en = 1'b1; par_odd = 1'b0;
        send_frame(8'hA7, 1'b1, 1'b1);
        check("R3 even mismatch", 32'(observed()), 32'(pack(1, 8'hA7, 0, 1, 0, 0)));
        read_both();
        par_odd = 1'b1;
        send_frame(8'h3C, 1'b1, 1'b1);
        check("R3 odd mismatch", 32'(observed()), 32'(pack(1, 8'h3C, 0, 1, 0, 0)));
        read_both();
        par_en = 1'b0; par_odd = 1'b0;

        // R4: one-tick low pulse is ignored
        hold(1'b0, TICKDIV);
        hold(1'b1, 12 * BITCLK);
        check("R4 glitch ignored", 32'(data_ready), 32'd0);
        send_frame(8'h5A, 1'b0, 1'b1);
        check("R4 frame after glitch", 32'(observed()), 32'(pack(1, 8'h5A, 0, 0, 0, 0)));
        read_both();

        // R5: start that is high again by its midpoint
        hold(1'b0, 5 * TICKDIV);
        hold(1'b1, 12 * BITCLK);
        check("R5 false start", 32'(data_ready), 32'd0);
        send_frame(8'hC3, 1'b0, 1'b1);
        check("R5 frame after false start", 32'(observed()), 32'(pack(1, 8'hC3, 0, 0, 0, 0)));

        // R6: buffer read clears only data_ready
        rd_data_strobe = 1'b1; @(negedge clk); rd_data_strobe = 1'b0; @(negedge clk);
        check("R6 read clears ready", 32'(observed()), 32'(pack(0, 8'hC3, 0, 0, 0, 0)));

        // R7: second character while first unread
        send_frame(8'h11, 1'b0, 1'b1);
        send_frame(8'h22, 1'b0, 1'b1);
        check("R7 overrun keeps old", 32'(observed()), 32'(pack(1, 8'h11, 1, 0, 0, 0)));
        read_both();
        check("R10 flags cleared", 32'(observed()), 32'(pack(0, 8'h11, 0, 0, 0, 0)));

        // R8: low stop bit, nonzero data
        send_frame(8'h55, 1'b0, 1'b0);
        check("R8 framing", 32'(observed()), 32'(pack(1, 8'h55, 0, 0, 1, 0)));
        read_both();

        // R9 / R8: line held low through a whole frame and beyond
        hold(1'b0, 13 * BITCLK);
        check("R9 break", 32'(observed()), 32'(pack(1, 8'h00, 0, 0, 1, 1)));
        read_both();
        hold(1'b0, 3 * BITCLK);
        hold(1'b1, 2 * BITCLK);
        check("R8 no restart while low", 32'(data_ready), 32'd0);

        // R11: forced errors on good characters
        force_perr = 1'b1;
        send_frame(8'h81, 1'b0, 1'b1);
        check("R11 forced parity", 32'(observed()), 32'(pack(1, 8'h81, 0, 1, 0, 0)));
        read_both();
        force_perr = 1'b0; force_ferr = 1'b1;
        send_frame(8'h7E, 1'b0, 1'b1);
        check("R11 forced framing", 32'(observed()), 32'(pack(1, 8'h7E, 0, 0, 1, 0)));
        read_both();
        force_ferr = 1'b0;

        // R10: set beats clear while both reads are held
        par_en = 1'b1;
        rd_data_strobe = 1'b1; rd_status_strobe = 1'b1;
        seen_pe = 1'b0; seen_dr = 1'b0; mon_en = 1'b1;
        send_frame(8'h0F, 1'b1, 1'b1);
        mon_en = 1'b0;
        rd_data_strobe = 1'b0; rd_status_strobe = 1'b0;
        @(negedge clk);
        check("R10 parity set wins", 32'(seen_pe), 32'd1);
        check("R10 ready set wins", 32'(seen_dr), 32'd1);
        check("R10 cleared after", 32'(observed()), 32'(pack(0, 8'h0F, 0, 0, 0, 0)));
        par_en = 1'b0;

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule